// File: doc/BRIEF.md
# Cycle and Retired-Instruction Counter Unit

This unit holds two free-running event counters for a small in-order pipelined core. One advances on every clock. The other advances only in cycles where the pipeline marks the instruction in its final stage as valid. Slots emptied by flushes, stalls or a frozen core therefore add nothing to the retired count. Software can compare the two values to judge how well the pipeline is used.

Each counter is `CNT_WIDTH` bits wide, 64 by default, and is held as a low and a high half. Each half appears on a combinational, read-only CSR read port at its own fixed address. No write path exists. Any address outside the four counter addresses reads as zero with the hit flag low. The returned value is the one held at the start of the current cycle, before that cycle's increment.

Top module: `perf_counters`

## Requirements
- R1: While reset is high at a clock edge, both counters are cleared, so all four counter addresses read zero after that edge.
- R2: The cycle counter increases by exactly one at every clock edge at which reset is low.
- R3: The retired counter increases by one at a clock edge only when `retireValid` is 1. When `retireValid` is 0 it holds its value.
- R4: Address 0xC00 returns the cycle counter's low half and 0xC80 its high half. Address 0xC02 returns the retired counter's low half and 0xC82 its high half. `csrHit` is 1 for each of these four addresses.
- R5: Any other address returns all-zero data with `csrHit` at 0.
- R6: Read data is combinational from `csrAddr`. It shows the counter value as it stood before the clock edge that ends the current cycle.
- R7: When the low half is all ones and the counter advances, the low half goes to zero and the high half increases by one at the same edge.
- R8: A counter that is all ones and advances wraps to zero, and no other indication is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| retireValid | input | 1 | Final pipeline stage holds a valid instruction this cycle |
| csrAddr | input | 12 | CSR read address |
| csrRdata | output | CNT_WIDTH/2 | Selected counter half, or zero |
| csrHit | output | 1 | Address matches one of the four counter halves |

## Verification
The assertions assume that reset is held for at least one clock edge before any check applies. They also assume that `retireValid` and `csrAddr` are stable around each rising edge. The bench meets both: it holds reset for several cycles and changes every input only on the falling edge. Carry and wrap cannot be reached at 64 bits in a short run. A second instance built with an 8-bit counter is therefore driven by the same `retireValid` and `csrAddr` stimulus, so that carry into the high half and full wrap occur many times. The retire strobe runs through steady-high, alternating, idle and pseudo-random phases.

// File: rtl/perf_counters_pkg.sv
package perf_counters_pkg;

  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] ADDR_CYC_LO = 12'hC00;
  localparam logic [ADDR_W-1:0] ADDR_CYC_HI = 12'hC80;
  localparam logic [ADDR_W-1:0] ADDR_RET_LO = 12'hC02;
  localparam logic [ADDR_W-1:0] ADDR_RET_HI = 12'hC82;

  localparam int NUM_CTRS = 2;
  localparam int IDX_CYC  = 0;
  localparam int IDX_RET  = 1;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CYC_LO,
    SEL_CYC_HI,
    SEL_RET_LO,
    SEL_RET_HI
  } rdSel_t;

  typedef struct packed {
    logic   cycInc;
    logic   retInc;
    rdSel_t rdSel;
  } ctrStrobes_t;

endpackage

// File: rtl/perf_split_counter.sv
module perf_split_counter #(
  parameter int CNT_WIDTH = 64,
  localparam int HALF_W = CNT_WIDTH / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  output logic [HALF_W-1:0] loHalf,
  output logic [HALF_W-1:0] hiHalf
);

  logic loFull;
  logic carry;

  assign loFull = &loHalf;
  assign carry  = inc & loFull;

  always_ff @(posedge clk) begin
    if (rst) begin
      loHalf <= '0;
    end else if (inc) begin
      loHalf <= loHalf + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hiHalf <= '0;
    end else if (carry) begin
      hiHalf <= hiHalf + 1'b1;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> ({hiHalf, loHalf} == '0)); // R1
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    inc |=> ({hiHalf, loHalf} == CNT_WIDTH'($past({hiHalf, loHalf}) + 1'b1))); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable({hiHalf, loHalf})); // R3
  AST_CARRY_SAME_EDGE: assert property (@(posedge clk) disable iff (rst)
    (inc && (&loHalf)) |=> (loHalf == '0 && hiHalf == HALF_W'($past(hiHalf) + 1'b1))); // R7
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (inc && (&{hiHalf, loHalf})) |=> ({hiHalf, loHalf} == '0)); // R8

endmodule

// File: rtl/perf_counters_ctrl.sv
module perf_counters_ctrl
  import perf_counters_pkg::*;
(
  input  logic              retireValid,
  input  logic [ADDR_W-1:0] csrAddr,
  output ctrStrobes_t       strobes,
  output logic              csrHit
);

  logic [3:0] addrMatch;

  assign addrMatch[0] = (csrAddr == ADDR_CYC_LO);
  assign addrMatch[1] = (csrAddr == ADDR_CYC_HI);
  assign addrMatch[2] = (csrAddr == ADDR_RET_LO);
  assign addrMatch[3] = (csrAddr == ADDR_RET_HI);

  always_comb begin
    strobes.cycInc = 1'b1;
    strobes.retInc = retireValid;
    unique case (1'b1)
      addrMatch[0]: strobes.rdSel = SEL_CYC_LO;
      addrMatch[1]: strobes.rdSel = SEL_CYC_HI;
      addrMatch[2]: strobes.rdSel = SEL_RET_LO;
      addrMatch[3]: strobes.rdSel = SEL_RET_HI;
      default:      strobes.rdSel = SEL_NONE;
    endcase
  end

  assign csrHit = |addrMatch;

  always_comb begin
    AST_DECODE_EXCLUSIVE: assert ($onehot0(addrMatch) || $isunknown(csrAddr)); // R4
  end

endmodule

// File: rtl/perf_counters_datapath.sv
module perf_counters_datapath
  import perf_counters_pkg::*;
#(
  parameter int CNT_WIDTH = 64,
  localparam int HALF_W = CNT_WIDTH / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrStrobes_t       strobes,
  output logic [HALF_W-1:0] rdData
);

  logic [NUM_CTRS-1:0] incVec;
  logic [HALF_W-1:0]   loVal [NUM_CTRS];
  logic [HALF_W-1:0]   hiVal [NUM_CTRS];

  assign incVec[IDX_CYC] = strobes.cycInc;
  assign incVec[IDX_RET] = strobes.retInc;

  for (genvar g = 0; g < NUM_CTRS; g++) begin : gCtr
    perf_split_counter #(.CNT_WIDTH(CNT_WIDTH)) i_ctr (
      .clk    (clk),
      .rst    (rst),
      .inc    (incVec[g]),
      .loHalf (loVal[g]),
      .hiHalf (hiVal[g])
    );
  end

  always_comb begin
    case (strobes.rdSel)
      SEL_CYC_LO: rdData = loVal[IDX_CYC];
      SEL_CYC_HI: rdData = hiVal[IDX_CYC];
      SEL_RET_LO: rdData = loVal[IDX_RET];
      SEL_RET_HI: rdData = hiVal[IDX_RET];
      default:    rdData = '0;
    endcase
  end

  logic [CNT_WIDTH-1:0] cycFull;
  assign cycFull = {hiVal[IDX_CYC], loVal[IDX_CYC]};

  AST_CYCLE_EVERY_EDGE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cycFull == CNT_WIDTH'($past(cycFull) + 1'b1))); // R2

endmodule

// File: rtl/perf_counters.sv
module perf_counters
  import perf_counters_pkg::*;
#(
  parameter int CNT_WIDTH = 64,
  localparam int HALF_W = CNT_WIDTH / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              retireValid,
  input  logic [11:0]       csrAddr,
  output logic [HALF_W-1:0] csrRdata,
  output logic              csrHit
);

  ctrStrobes_t strobes;

  perf_counters_ctrl i_ctrl (
    .retireValid (retireValid),
    .csrAddr     (csrAddr),
    .strobes     (strobes),
    .csrHit      (csrHit)
  );

  perf_counters_datapath #(.CNT_WIDTH(CNT_WIDTH)) i_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .rdData  (csrRdata)
  );

  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !csrHit |-> (csrRdata == '0)); // R5

endmodule

// File: tb/test_perf_counters.sv
`timescale 1ns/1ps
module test_perf_counters;

  localparam int SMALL_W = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        retireValid = 1'b0;
  logic [11:0] csrAddr = 12'h000;
  logic [31:0] bigData;
  logic        bigHit;
  logic [SMALL_W/2-1:0] smallData;
  logic        smallHit;

  always #2 clk = ~clk;

  perf_counters i_perf_counters (
    .clk(clk), .rst(rst), .retireValid(retireValid),
    .csrAddr(csrAddr), .csrRdata(bigData), .csrHit(bigHit)
  );

  perf_counters #(.CNT_WIDTH(SMALL_W)) i_perf_counters_small (
    .clk(clk), .rst(rst), .retireValid(retireValid),
    .csrAddr(csrAddr), .csrRdata(smallData), .csrHit(smallHit)
  );

  typedef struct {
    logic [31:0] expBig;
    logic [3:0]  expSmall;
    logic        expHit;
    logic [11:0] addr;
    string       tag;
  } item_t;

  item_t scoreQ[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [63:0] mCyc, mRet;

  // reference counters, updated at the edge with the inputs held since the falling edge
  always @(posedge clk) begin
    if (rst) begin
      mCyc <= '0;
      mRet <= '0;
    end else begin
      mCyc <= mCyc + 64'd1;
      if (retireValid) mRet <= mRet + 64'd1;
    end
  end

  task automatic doRead(input logic [11:0] a);
    item_t it;
    logic [7:0] sc, sr;
    @(negedge clk);
    csrAddr = a;
    sc = mCyc[7:0];
    sr = mRet[7:0];
    it.addr = a;
    it.expHit = 1'b1;
    case (a)
      12'hC00: begin it.expBig = mCyc[31:0];  it.expSmall = sc[3:0]; it.tag = "R2 R4 R6"; end
      12'hC80: begin it.expBig = mCyc[63:32]; it.expSmall = sc[7:4]; it.tag = "R4 R7"; end
      12'hC02: begin it.expBig = mRet[31:0];  it.expSmall = sr[3:0]; it.tag = "R3 R4 R6"; end
      12'hC82: begin it.expBig = mRet[63:32]; it.expSmall = sr[7:4]; it.tag = "R4 R7"; end
      default: begin it.expBig = '0; it.expSmall = '0; it.expHit = 1'b0; it.tag = "R5"; end
    endcase
    if (rst) it.tag = "R1";
    scoreQ.push_back(it);
  endtask

  // monitor: compares shortly after the driver has set the address
  always @(negedge clk) begin
    #1;
    while (scoreQ.size() > 0) begin
      item_t it;
      it = scoreQ.pop_front();
      checks++;
      if (bigData !== it.expBig || bigHit !== it.expHit) begin
        failures++;
        $display("FAIL %s addr=%h wide: data=%h hit=%b expected data=%h hit=%b",
                 it.tag, it.addr, bigData, bigHit, it.expBig, it.expHit);
      end
      checks++;
      if (smallData !== it.expSmall || smallHit !== it.expHit) begin
        failures++;
        $display("FAIL R7 R8 %s addr=%h narrow: data=%h hit=%b expected data=%h hit=%b",
                 it.tag, it.addr, smallData, smallHit, it.expSmall, it.expHit);
      end
    end
  end

  logic [11:0] addrList [8] = '{12'hC00, 12'hC80, 12'hC02, 12'hC82,
                                12'hC01, 12'h000, 12'hC81, 12'hB00};

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    // reads while reset is still asserted (R1)
    for (int i = 0; i < 5; i++) doRead(addrList[i]);
    @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < 1200; c++) begin
      @(negedge clk);
      if (c < 150) retireValid = 1'b1;
      else if (c < 300) retireValid = c[0];
      else if (c < 450) retireValid = 1'b0;
      else begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        retireValid = lfsr[0];
      end
      doRead(addrList[c % 8]);
    end
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule